// File: doc/BRIEF.md
# Fragmented-Bus I/Q Word Assembler

This block sits at the entry of a transmit path. It takes baseband samples from a narrow parallel bus and rebuilds them into 12-bit words. Each word can arrive as one full-width transfer, as two 6-bit halves, or as four 3-bit pieces. The configuration input selects the bus mode. The transmit enable works as a valve: a transfer counts only in a cycle where the enable is high.

Completed words alternate between in-phase and quadrature. The block pairs each I word with the Q word that follows it. It presents both as a registered 12-bit pair with a one-cycle valid strobe, so the pair rate is half the word rate. Dropping the enable discards any partial word and any unpaired I word. The next complete word is then taken as I again.

Top module: `iq_word_assembler`

## Requirements
- R1: With `bus_mode` = 2'b00 (and also 2'b11, which behaves the same), every enabled cycle delivers one complete word taken from `din[11:0]`.
- R2: With `bus_mode` = 2'b01, a word takes two enabled transfers on `din[5:0]`. The first transfer gives word bits 11:6 and the second gives bits 5:0. `din[11:6]` is ignored.
- R3: With `bus_mode` = 2'b10, a word takes four enabled transfers on `din[2:0]`, most significant piece first (bits 11:9, then 8:6, 5:3, 2:0). `din[11:3]` is ignored.
- R4: The first complete word after reset, or after `tx_en` rises, is the I component. Each following complete word alternates between Q and I.
- R5: `pair_valid` is high for exactly one cycle, on the cycle after the clock edge that samples the last transfer of a Q word. In that cycle `i_out`/`q_out` carry the pair. They hold their values in every other cycle.
- R6: While `tx_en` is low, `din` is ignored. The transfer count and the I/Q pairing return to their start state, so a partial word or an unpaired I word is discarded.
- R7: `bus_mode` is sampled only on clock edges where `tx_en` is low. A change made while `tx_en` is high has no effect until `tx_en` has been low for an edge.
- R8: Synchronous active-high `rst` clears `i_out`, `q_out` and `pair_valid` to zero and selects the 12-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transfer enable (valve) |
| bus_mode | input | 2 | Bus width select: 00 full, 01 halves, 10 quarters, 11 full |
| din | input | 12 | Data bus; narrow modes use the low bits |
| i_out | output | 12 | Assembled in-phase sample |
| q_out | output | 12 | Assembled quadrature sample |
| pair_valid | output | 1 | One-cycle strobe marking a new I/Q pair |

## Verification
The bench models each bus mode separately and checks the outputs after every cycle. A wrong transfer count or a wrong piece order shows as a corrupted word at the next `pair_valid`, at most two words later. A pairing phase that is wrong, or that is not cleared when the enable drops, puts I and Q in swapped positions or moves the strobe by one word. This shows within one pair time. A mode latch that follows the configuration while the enable is high changes the word length in the middle of the stream, and the checker reports it on the same edge.

// File: rtl/iqa_pkg.sv
package iqa_pkg;

  typedef enum logic [1:0] {
    BUS_FULL    = 2'b00,
    BUS_HALF    = 2'b01,
    BUS_QUARTER = 2'b10,
    BUS_ALTFULL = 2'b11
  } bus_mode_e;

  // number of transfers that make up one word in a given mode
  function automatic logic [2:0] transfers_per_word(bus_mode_e m);
    case (m)
      BUS_HALF:    return 3'd2;
      BUS_QUARTER: return 3'd4;
      default:     return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/iqa_mode_reg.sv
module iqa_mode_reg
  import iqa_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  input  logic [1:0] cfg_mode,
  output bus_mode_e mode_q
);

  // configuration is only taken while the valve is closed
  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= BUS_FULL;
    else if (!tx_en)
      mode_q <= bus_mode_e'(cfg_mode);
  end

endmodule

// File: rtl/iqa_frag_gather.sv
module iqa_frag_gather
  import iqa_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  bus_mode_e         mode,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word,
  output logic              word_done
);

  localparam int HALF_W = WORD_W / 2;
  localparam int QTR_W  = WORD_W / 4;
  localparam int ACC_W  = WORD_W - QTR_W;

  logic [1:0]       cnt;
  logic [ACC_W-1:0] acc;
  logic             last;
  logic [WORD_W-1:0] word_next;

  always_comb begin
    case (mode)
      BUS_HALF: begin
        last      = (cnt == 2'd1);
        word_next = {acc[HALF_W-1:0], din[HALF_W-1:0]};
      end
      BUS_QUARTER: begin
        last      = (cnt == 2'd3);
        word_next = {acc, din[QTR_W-1:0]};
      end
      default: begin
        last      = 1'b1;
        word_next = din;
      end
    endcase
  end

  assign word      = word_next;
  assign word_done = tx_en & last;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      cnt <= '0;
      acc <= '0;
    end else if (last) begin
      cnt <= '0;
      acc <= '0;
    end else begin
      cnt <= cnt + 2'd1;
      acc <= word_next[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/iqa_pair_demux.sv
module iqa_pair_demux #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic [WORD_W-1:0] word,
  input  logic              word_done,
  output logic [WORD_W-1:0] i_out,
  output logic [WORD_W-1:0] q_out,
  output logic              pair_valid
);

  logic              q_next;
  logic [WORD_W-1:0] i_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_next     <= 1'b0;
      i_hold     <= '0;
      i_out      <= '0;
      q_out      <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (!tx_en) begin
        q_next <= 1'b0;
      end else if (word_done) begin
        if (!q_next) begin
          i_hold <= word;
          q_next <= 1'b1;
        end else begin
          i_out      <= i_hold;
          q_out      <= word;
          pair_valid <= 1'b1;
          q_next     <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/iq_word_assembler.sv
module iq_word_assembler
  import iqa_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic [1:0]        bus_mode,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] i_out,
  output logic [WORD_W-1:0] q_out,
  output logic              pair_valid
);

  bus_mode_e         mode_q;
  logic [WORD_W-1:0] word;
  logic              word_done;

  iqa_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .cfg_mode (bus_mode),
    .mode_q   (mode_q)
  );

  iqa_frag_gather #(.WORD_W(WORD_W)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .mode      (mode_q),
    .din       (din),
    .word      (word),
    .word_done (word_done)
  );

  iqa_pair_demux #(.WORD_W(WORD_W)) u_pair (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .word       (word),
    .word_done  (word_done),
    .i_out      (i_out),
    .q_out      (q_out),
    .pair_valid (pair_valid)
  );

endmodule

// File: rtl/iqa_checker.sv
module iqa_checker #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic [1:0]        mode_q,
  input logic              word_done,
  input logic [WORD_W-1:0] i_out,
  input logic [WORD_W-1:0] q_out,
  input logic              pair_valid
);

  // R5
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  // R5
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> ($stable(i_out) && $stable(q_out)));

  // R5
  valid_follows_word_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> $past(word_done));

  // R6
  closed_valve_no_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !pair_valid);

  // R6
  closed_valve_no_word_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> !word_done);

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && $past(tx_en)) |-> $stable(mode_q));

endmodule

bind iq_word_assembler iqa_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_en      (tx_en),
  .mode_q     (mode_q),
  .word_done  (word_done),
  .i_out      (i_out),
  .q_out      (q_out),
  .pair_valid (pair_valid)
);

// File: tb/iq_word_assembler_test.sv
`timescale 1ns/1ps
module iq_word_assembler_test;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tx_en = 1'b0;
  logic [1:0]   bus_mode = 2'b00;
  logic [W-1:0] din = '0;
  logic [W-1:0] i_out, q_out;
  logic         pair_valid;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R8";

  // bench reference state
  int           m_mode = 0;
  int           m_cnt = 0;
  int           m_acc = 0;
  bit           m_phase = 0;
  int           m_ihold = 0;
  logic         exp_valid = 1'b0;
  logic [W-1:0] exp_i = '0;
  logic [W-1:0] exp_q = '0;

  always #2 clk = ~clk;

  iq_word_assembler uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bus_mode(bus_mode),
    .din(din), .i_out(i_out), .q_out(q_out), .pair_valid(pair_valid)
  );

  function automatic int nfrag(int m);
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  function automatic int fwidth(int m);
    return W / nfrag(m);
  endfunction

  // compare outputs of the previous edge, then drive the next cycle
  task automatic step(input bit en, input int d);
    @(negedge clk);
    checks++;
    if (pair_valid !== exp_valid || i_out !== exp_i || q_out !== exp_q) begin
      fails++;
      $display("FAIL %s: got v=%0b i=%03h q=%03h, expected v=%0b i=%03h q=%03h",
               cur_req, pair_valid, i_out, q_out, exp_valid, exp_i, exp_q);
    end
    tx_en = en;
    din   = d[W-1:0];
    exp_valid = 1'b0;
    if (!en) begin
      m_cnt = 0; m_acc = 0; m_phase = 0;
      m_mode = bus_mode;
    end else begin
      m_acc = ((m_acc << fwidth(m_mode)) | (d & ((1 << fwidth(m_mode)) - 1))) & 12'hFFF;
      m_cnt++;
      if (m_cnt == nfrag(m_mode)) begin
        if (!m_phase) begin
          m_ihold = m_acc; m_phase = 1;
        end else begin
          exp_i = m_ihold[W-1:0]; exp_q = m_acc[W-1:0];
          exp_valid = 1'b1; m_phase = 0;
        end
        m_cnt = 0; m_acc = 0;
      end
    end
  endtask

  // send a word in the current reference mode; unused upper bits carry junk
  task automatic send_word(input int w, input int junk);
    int nf, fw, frag;
    nf = nfrag(m_mode);
    fw = fwidth(m_mode);
    for (int f = 0; f < nf; f++) begin
      frag = (w >> (fw * (nf - 1 - f))) & ((1 << fw) - 1);
      step(1'b1, (junk & ~((1 << fw) - 1) & 12'hFFF) | frag);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: reset state
    cur_req = "R8";
    step(1'b0, 0);
    step(1'b0, 12'hFFF);

    // R1 R2 R3 R4 R5: sweep of every mode code
    for (int m = 0; m < 4; m++) begin
      cur_req = (m == 1) ? "R2 R4 R5" : (m == 2) ? "R3 R4 R5" : "R1 R4 R5";
      bus_mode = m[1:0];
      step(1'b0, 12'h5A5);
      step(1'b0, 0);
      for (int k = 0; k < 48; k++)
        send_word((k * 1103 + m * 77 + 5) & 12'hFFF, (k * 2731) & 12'hFFF);
    end

    // R6: partial quarter word dropped, junk ignored while closed
    cur_req = "R6";
    bus_mode = 2'b10;
    step(1'b0, 0);
    step(1'b1, 3'h7);
    step(1'b1, 3'h5);
    for (int k = 0; k < 4; k++) step(1'b0, k * 1001);
    send_word(12'h123, 12'hE38);
    send_word(12'hABC, 12'h1C7);

    // R6: unpaired I word dropped, pairing restarts with I
    bus_mode = 2'b01;
    step(1'b0, 0);
    send_word(12'h9F0, 12'hFC0);
    step(1'b0, 12'hFFF);
    send_word(12'h456, 0);
    send_word(12'h789, 12'hFC0);

    // R7: mode change while enabled has no effect until the valve closes
    cur_req = "R7";
    bus_mode = 2'b00;
    step(1'b0, 0);
    send_word(12'h111, 0);
    bus_mode = 2'b10;
    for (int k = 0; k < 6; k++) send_word(12'h2E1 + k * 97, 0);
    step(1'b0, 0);
    for (int k = 0; k < 6; k++) send_word(12'h84D + k * 211, 12'hFF8);

    // R5: back-to-back full-width pairs, strobe every other cycle
    cur_req = "R5";
    bus_mode = 2'b00;
    step(1'b0, 0);
    for (int k = 0; k < 16; k++) send_word(k * 257, 0);
    step(1'b0, 0);
    step(1'b0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule